// File: doc/BRIEF.md
# Pulse-Triggered Task Activation Unit

This block is one control point in a chain of them, built for a synchronous design. It has several active-low advance-in strobe lines. A low pulse on any one of them arms the unit. Once every advance-in line is high again, the unit drives an active-low task strobe, which starts the work of this step. It then drives an active-low advance-out strobe, which is wired to an advance-in line of the next unit in the chain. All strobes idle high, and an event is a high-low-high pulse.

A parameter selects one of two modes. In untimed mode the task strobe lasts one clock cycle. In timed mode the task strobe is held low for a fixed number of cycles, which stands in for the duration of the task. In both modes the advance-out pulse lasts one cycle, whatever the task length. An active-low common-clear input returns the unit to idle at once.

Top module: `task_strobe_unit`

## Requirements
- R1: While `clr_n` is low, and in the idle state after it, `task_n` and `adv_out_n` are both high (1).
- R2: `adv_in_n` lines are sampled at the rising edge of `clk`. Any line sampled low while the unit is idle arms the unit. While the unit is armed, further lows on the same line or on other lines merge into the same single activation.
- R3: `task_n` stays high for as long as any `adv_in_n` line is sampled low. It goes low in the first cycle after the edge at which all lines are sampled high again.
- R4: `adv_out_n` is low for exactly one cycle. That cycle directly follows the last low cycle of `task_n`, and the two outputs are never low together.
- R5: With `TIMED=1`, `task_n` is low for exactly `DELAY_CYCLES` consecutive cycles (at least 1). The `adv_out_n` pulse that follows is still exactly one cycle wide.
- R6: With `TIMED=0`, `task_n` is low for exactly one cycle, and `adv_out_n` is low in the cycle after it.
- R7: `adv_in_n` lows sampled while `task_n` or `adv_out_n` is low are ignored. Each activation yields exactly one task pulse and one advance-out pulse, and the unit then idles.
- R8: A low level on `clr_n` is asynchronous. It immediately forces both outputs high and drops any armed or running activation, so no strobe follows when the clear is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr_n | input | 1 | Common clear, active low, asynchronous |
| adv_in_n | input | N_IN | Advance-in strobes, active low |
| task_n | output | 1 | Task strobe, active low |
| adv_out_n | output | 1 | Advance-out strobe, active low |

## Verification
On every cycle, the assertions check the following:
- the advance-out pulse is one cycle wide and comes straight after a task cycle;
- the two strobes never overlap;
- a task strobe starts only after all inputs were high;
- in untimed mode the task strobe lasts one cycle;
- clear holds both outputs high.

Several behaviours can only be shown by the bench's scenarios:
- the exact timed task width;
- merging of overlapping input pulses;
- pulses arriving during a busy phase being dropped;
- a clear in mid-task losing the pending advance-out strobe.

// File: rtl/task_strobe_unit.sv
module task_strobe_unit #(
  parameter int N_IN         = 3,
  parameter bit TIMED        = 1'b1,
  parameter int DELAY_CYCLES = 5
) (
  input  logic            clk,
  input  logic            clr_n,
  input  logic [N_IN-1:0] adv_in_n,
  output logic            task_n,
  output logic            adv_out_n
);

  localparam int HOLD = TIMED ? DELAY_CYCLES : 1;
  localparam int CW   = (HOLD > 1) ? $clog2(HOLD) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_TASK, S_ADV} st_t;

  st_t           state;
  logic [CW-1:0] cnt;

  wire any_low = ~&adv_in_n;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE:  if (any_low) state <= S_ARMED;
        S_ARMED: if (!any_low) begin
                   state <= S_TASK;
                   cnt   <= CW'(HOLD - 1);
                 end
        S_TASK:  if (cnt == '0) state <= S_ADV;
                 else cnt <= cnt - 1'b1;
        S_ADV:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign task_n    = (state != S_TASK);
  assign adv_out_n = (state != S_ADV);

endmodule

// File: rtl/task_strobe_unit_chk.sv
module task_strobe_unit_chk #(
  parameter int N_IN         = 3,
  parameter bit TIMED        = 1'b1,
  parameter int DELAY_CYCLES = 5
) (
  input logic            clk,
  input logic            clr_n,
  input logic [N_IN-1:0] adv_in_n,
  input logic            task_n,
  input logic            adv_out_n
);

  // R1 R8
  clear_quiet_chk: assert property (@(posedge clk)
    !clr_n |-> (task_n && adv_out_n));

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !(!task_n && !adv_out_n));

  // R4
  adv_one_cycle_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !adv_out_n |=> adv_out_n);

  // R4
  adv_after_task_chk: assert property (@(posedge clk) disable iff (!clr_n)
    $fell(adv_out_n) |-> $past(!task_n));

  // R3
  task_after_release_chk: assert property (@(posedge clk) disable iff (!clr_n)
    $fell(task_n) |-> $past(&adv_in_n));

  // R6
  untimed_width_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!TIMED && !task_n) |=> task_n);

endmodule

bind task_strobe_unit task_strobe_unit_chk #(
  .N_IN(N_IN), .TIMED(TIMED), .DELAY_CYCLES(DELAY_CYCLES)
) u_chk (
  .clk(clk), .clr_n(clr_n), .adv_in_n(adv_in_n),
  .task_n(task_n), .adv_out_n(adv_out_n)
);

// File: tb/tb_task_strobe_unit.sv
module tb_task_strobe_unit;
  localparam int N = 3;
  localparam int DLY = 5;

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic [N-1:0] in_t_n = '1;
  logic [N-1:0] in_u_n = '1;
  logic t_task_n, t_adv_n, u_task_n, u_adv_n;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  task_strobe_unit #(.N_IN(N), .TIMED(1'b1), .DELAY_CYCLES(DLY)) dut (
    .clk(clk), .clr_n(clr_n), .adv_in_n(in_t_n), .task_n(t_task_n), .adv_out_n(t_adv_n));
  task_strobe_unit #(.N_IN(N), .TIMED(1'b0), .DELAY_CYCLES(DLY)) dut_u (
    .clk(clk), .clr_n(clr_n), .adv_in_n(in_u_n), .task_n(u_task_n), .adv_out_n(u_adv_n));

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic watch(input bit timed, input int n,
                       output int tl, output int tf, output int al, output int af);
    tl = 0; al = 0; tf = -1; af = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (!(timed ? t_task_n : u_task_n)) begin tl++; if (tf < 0) tf = i; end
      if (!(timed ? t_adv_n : u_adv_n))   begin al++; if (af < 0) af = i; end
    end
  endtask

  task automatic drive(input bit timed, input int line, input int len, input string rq);
    int hi;
    @(negedge clk);
    if (timed) in_t_n[line] = 1'b0; else in_u_n[line] = 1'b0;
    hi = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if ((timed ? t_task_n : u_task_n) && (timed ? t_adv_n : u_adv_n)) hi++;
    end
    check(hi == len, rq, hi, len);
    if (timed) in_t_n[line] = 1'b1; else in_u_n[line] = 1'b1;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check(t_task_n && t_adv_n, "R1 timed", {t_task_n, t_adv_n}, 3);
    check(u_task_n && u_adv_n, "R1 untimed", {u_task_n, u_adv_n}, 3);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    check(t_task_n && t_adv_n && u_task_n && u_adv_n, "R1 idle", 0, 0);
  endtask

  task automatic t_untimed();
    int tl, tf, al, af;
    drive(1'b0, 0, 3, "R3 untimed hold");
    watch(1'b0, 8, tl, tf, al, af);
    check(tl == 1, "R6 width", tl, 1);
    check(tf == 1, "R3 start", tf, 1);
    check(al == 1 && af == 2, "R6 R4 adv", af, 2);
  endtask

  task automatic t_timed();
    int tl, tf, al, af;
    drive(1'b1, 2, 1, "R3 timed hold");
    watch(1'b1, 12, tl, tf, al, af);
    check(tl == DLY && tf == 1, "R5 width", tl, DLY);
    check(al == 1, "R5 adv width", al, 1);
    check(af == DLY + 1, "R4 adv position", af, DLY + 1);
  endtask

  task automatic t_merge();
    int tl, tf, al, af, hi;
    @(negedge clk); in_u_n[0] = 1'b0;
    @(negedge clk); in_u_n[1] = 1'b0;
    @(negedge clk); in_u_n[0] = 1'b1;
    hi = 0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (u_task_n && u_adv_n) hi++; end
    check(hi == 3, "R3 other line low", hi, 3);
    in_u_n[1] = 1'b1;
    watch(1'b0, 10, tl, tf, al, af);
    check(tl == 1 && tf == 1, "R2 merged activation", tl, 1);
    check(al == 1, "R2 merged adv", al, 1);
  endtask

  task automatic t_busy();
    int tl, al, tf, af;
    drive(1'b1, 0, 2, "R3 busy hold");
    tl = 0; al = 0; af = -1;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (!t_task_n) tl++;
      if (!t_adv_n) begin al++; if (af < 0) af = i; end
      if (i == 2) in_t_n[1] = 1'b0;
      if (i == 4) in_t_n[1] = 1'b1;
      if (i == 6) in_t_n[2] = 1'b0;
      if (i == 7) in_t_n[2] = 1'b1;
    end
    check(tl == DLY, "R7 task count", tl, DLY);
    check(al == 1 && af == DLY + 1, "R7 adv count", al, 1);
    watch(1'b1, 6, tl, tf, al, af);
    check(tl == 0 && al == 0, "R7 stays idle", tl + al, 0);
  endtask

  task automatic t_clear();
    int tl, tf, al, af;
    drive(1'b1, 2, 1, "R3 clear hold");
    repeat (2) @(negedge clk);
    check(!t_task_n, "R5 running before clear", t_task_n, 0);
    clr_n = 1'b0;
    #1;
    check(t_task_n && t_adv_n, "R8 immediate", {t_task_n, t_adv_n}, 3);
    @(negedge clk); clr_n = 1'b1;
    watch(1'b1, 10, tl, tf, al, af);
    check(tl == 0 && al == 0, "R8 dropped", tl + al, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_untimed();
    t_timed();
    t_merge();
    t_busy();
    t_clear();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule